// File: doc/BRIEF.md
# Write-Through Invalidating Snoop Cache Controller

This block controls a direct-mapped, one-word-per-line cache placed between a processor and a single shared bus. Main memory is never stale: every processor store becomes a bus write, and on a store miss the word is fetched before it is written. Loads that hit are answered from the local array without touching the bus. Loads that miss fetch the word over the bus and install it in the line. A line that is replaced is simply overwritten, because memory already holds its value.

The controller also watches the bus for write cycles. When another master writes an address whose line is valid here, that line is cleared, so the next local access misses and reads fresh data. Write cycles this controller issued itself are flagged on the snoop port and leave the array untouched. The processor holds its request until `cpuReady` is high for one cycle. The bus side holds one command until memory pulses `busDone`.

Top module: `wt_snoop_cache`

## Requirements
- R1: A load whose line is invalid or carries another tag issues one bus read (`busCmdValid`=1, `busCmdWrite`=0) at the word address. `cpuReady` is high in the `busDone` cycle with `cpuRdata` equal to `busRdata`. The line then holds that word.
- R2: A load that hits is answered with `cpuReady`=1 in the cycle it is first presented, with the stored word, and no bus command follows.
- R3: A store that hits issues exactly one bus write (`busCmdWrite`=1) carrying the request's address and data. Afterwards the line returns the stored value.
- R4: A store that misses issues a bus read first and then a bus write of the store data. Afterwards the line hits with the stored value.
- R5: Replacing a line with a different tag at the same index issues no bus write. The evicted address misses on its next load.
- R6: A foreign snooped write (`snoopValid`=1, `snoopSelf`=0) whose address matches a valid line clears that line.
- R7: A foreign snooped write to the same index but another tag leaves the line valid.
- R8: A snooped write with `snoopSelf`=1 never changes any line.
- R9: When a foreign snoop clears the line that a processor access looks up in the same cycle, the snoop wins and the access is handled as a miss.
- R10: While a bus command is outstanding, `cpuReady` stays low and the command and its address stay stable. `cpuReady` is asserted only in the cycle `busDone` is seen.
- R11: After reset all lines are invalid, `cpuReady` is low and no bus command is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, held until cpuReady |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | ADDR_W | Word address |
| cpuWdata | input | DATA_W | Store data |
| cpuRdata | output | DATA_W | Load data, valid with cpuReady |
| cpuReady | output | 1 | Request complete |
| busCmdValid | output | 1 | Bus command active |
| busCmdWrite | output | 1 | 1 = bus write, 0 = bus read |
| busAddr | output | ADDR_W | Bus word address |
| busWdata | output | DATA_W | Bus write data |
| busRdata | input | DATA_W | Bus read data, valid with busDone |
| busDone | input | 1 | One-cycle completion of the bus command |
| snoopValid | input | 1 | A write cycle is on the bus |
| snoopSelf | input | 1 | That write was issued by this controller |
| snoopAddr | input | ADDR_W | Address of the snooped write |

## Verification
The hardest case to reach from the ports is a foreign snoop that lands in the exact cycle a hitting load is first looked up. The bench sets the snoop and the request on the same falling edge. It then confirms that no early `cpuReady` appears and that a bus read follows. Snoops to a sibling tag and self-flagged snoops are placed between a fill and a re-read. Their lack of effect is then seen as a zero-bus-traffic hit.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_WRITE = 2'd2
  } ctlState_t;

  typedef struct packed {
    logic capture;      // latch the processor request
    logic lineWrite;    // install a word into the request's line
    logic fillFromBus;  // line data comes from the bus, not the store data
    logic rdFromBus;    // processor read data comes straight from the bus
  } ctlStrobes_t;

endpackage

// File: rtl/wt_cache_datapath.sv
module wt_cache_datapath
  import wt_cache_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              cpuWe,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              snoopValid,
  input  logic              snoopSelf,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              lookupHit,
  output logic              reqWe,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] cpuRdata
);

  localparam int LINES = 1 << INDEX_W;
  localparam int TAG_W = ADDR_W - INDEX_W;

  logic [LINES-1:0]  validQ;
  logic [TAG_W-1:0]  tagQ  [LINES];
  logic [DATA_W-1:0] dataQ [LINES];

  logic [INDEX_W-1:0] cpuIdx, snoopIdx, reqIdx;
  logic [TAG_W-1:0]   cpuTag, snoopTag, reqTag;

  assign cpuIdx   = cpuAddr[INDEX_W-1:0];
  assign cpuTag   = cpuAddr[ADDR_W-1:INDEX_W];
  assign snoopIdx = snoopAddr[INDEX_W-1:0];
  assign snoopTag = snoopAddr[ADDR_W-1:INDEX_W];
  assign reqIdx   = reqAddr[INDEX_W-1:0];
  assign reqTag   = reqAddr[ADDR_W-1:INDEX_W];

  logic foreignSnoop, snoopOldMatch, snoopNewMatch;
  logic [DATA_W-1:0] lineData;

  assign foreignSnoop  = snoopValid && !snoopSelf;
  // foreign write hits a currently valid line
  assign snoopOldMatch = foreignSnoop && validQ[snoopIdx] && (tagQ[snoopIdx] == snoopTag);
  // foreign write hits the word being installed this cycle
  assign snoopNewMatch = foreignSnoop && strobes.lineWrite &&
                         (snoopIdx == reqIdx) && (snoopTag == reqTag);

  // a snoop that kills the looked-up line wins over the processor lookup
  assign lookupHit = validQ[cpuIdx] && (tagQ[cpuIdx] == cpuTag) &&
                     !(snoopOldMatch && (snoopIdx == cpuIdx));

  assign lineData = strobes.fillFromBus ? busRdata : reqWdata;
  assign cpuRdata = strobes.rdFromBus ? busRdata : dataQ[cpuIdx];

  // request latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqWe    <= 1'b0;
      reqAddr  <= '0;
      reqWdata <= '0;
    end else if (strobes.capture) begin
      reqWe    <= cpuWe;
      reqAddr  <= cpuAddr;
      reqWdata <= cpuWdata;
    end
  end

  // line storage, one slice per index
  for (genvar gi = 0; gi < LINES; gi++) begin : gLine
    logic selWrite, selKill;
    assign selWrite = strobes.lineWrite && (reqIdx == INDEX_W'(gi));
    assign selKill  = snoopOldMatch && (snoopIdx == INDEX_W'(gi));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[gi] <= 1'b0;
      end else if (selWrite) begin
        validQ[gi] <= !snoopNewMatch;
      end else if (selKill) begin
        validQ[gi] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (selWrite) begin
        tagQ[gi]  <= reqTag;
        dataQ[gi] <= lineData;
      end
    end
  end

  AST_SNOOP_CLEARS_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (snoopOldMatch && !(strobes.lineWrite && (reqIdx == snoopIdx)))
      |=> !validQ[$past(snoopIdx)]); // R6

  AST_SELF_SNOOP_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (snoopValid && snoopSelf && !strobes.lineWrite) |=> $stable(validQ)); // R8

  AST_FILL_VALIDATES: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.lineWrite && !snoopNewMatch) |=> validQ[$past(reqIdx)]); // R1

  AST_RESET_EMPTY: assert property (@(posedge clk)
    $rose(rstN) |-> (validQ == '0)); // R11

endmodule

// File: rtl/wt_cache_control.sv
module wt_cache_control
  import wt_cache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic        lookupHit,
  input  logic        reqWe,
  input  logic        busDone,
  output ctlStrobes_t strobes,
  output logic        busCmdValid,
  output logic        busCmdWrite,
  output logic        cpuReady
);

  ctlState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    strobes     = '0;
    busCmdValid = 1'b0;
    busCmdWrite = 1'b0;
    cpuReady    = 1'b0;
    case (state)
      S_IDLE: begin
        if (cpuReq) begin
          if (!cpuWe && lookupHit) begin
            cpuReady = 1'b1;
          end else begin
            strobes.capture = 1'b1;
            stateNext = (cpuWe && lookupHit) ? S_WRITE : S_FETCH;
          end
        end
      end
      S_FETCH: begin
        busCmdValid = 1'b1;
        if (busDone) begin
          strobes.lineWrite   = 1'b1;
          strobes.fillFromBus = 1'b1;
          if (reqWe) begin
            stateNext = S_WRITE;
          end else begin
            cpuReady          = 1'b1;
            strobes.rdFromBus = 1'b1;
            stateNext         = S_IDLE;
          end
        end
      end
      S_WRITE: begin
        busCmdValid = 1'b1;
        busCmdWrite = 1'b1;
        if (busDone) begin
          strobes.lineWrite = 1'b1;
          cpuReady          = 1'b1;
          stateNext         = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    ((state != S_IDLE) && cpuReady) |-> busDone); // R10

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busCmdValid && !busDone) |=> (busCmdValid && $stable(busCmdWrite))); // R10

  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_IDLE) && cpuReq && !cpuWe && lookupHit) |=> !busCmdValid); // R2

  AST_STORE_TO_BUS: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_IDLE) && cpuReq && cpuWe) |=> busCmdValid); // R3

  AST_FETCH_THEN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_FETCH) && busDone && reqWe) |=> (busCmdValid && busCmdWrite)); // R4

endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache
  import wt_cache_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuReady,
  output logic              busCmdValid,
  output logic              busCmdWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busDone,
  input  logic              snoopValid,
  input  logic              snoopSelf,
  input  logic [ADDR_W-1:0] snoopAddr
);

  ctlStrobes_t strobes;
  logic        lookupHit;
  logic        reqWe;

  wt_cache_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .INDEX_W(INDEX_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .cpuAddr   (cpuAddr),
    .cpuWdata  (cpuWdata),
    .cpuWe     (cpuWe),
    .strobes   (strobes),
    .busRdata  (busRdata),
    .snoopValid(snoopValid),
    .snoopSelf (snoopSelf),
    .snoopAddr (snoopAddr),
    .lookupHit (lookupHit),
    .reqWe     (reqWe),
    .reqAddr   (busAddr),
    .reqWdata  (busWdata),
    .cpuRdata  (cpuRdata)
  );

  wt_cache_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .cpuReq     (cpuReq),
    .cpuWe      (cpuWe),
    .lookupHit  (lookupHit),
    .reqWe      (reqWe),
    .busDone    (busDone),
    .strobes    (strobes),
    .busCmdValid(busCmdValid),
    .busCmdWrite(busCmdWrite),
    .cpuReady   (cpuReady)
  );

  AST_BUS_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busCmdValid && !busDone) |=> $stable(busAddr)); // R10

endmodule

// File: tb/wt_snoop_cache_bench.sv
`timescale 1ns/1ps
module wt_snoop_cache_bench;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int LAT    = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cpuReq = 1'b0, cpuWe = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [DATA_W-1:0] cpuWdata = '0;
  logic [DATA_W-1:0] cpuRdata;
  logic              cpuReady;
  logic              busCmdValid, busCmdWrite;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWdata;
  logic [DATA_W-1:0] busRdata = '0;
  logic              busDone = 1'b0;
  logic              snoopValid = 1'b0, snoopSelf = 1'b0;
  logic [ADDR_W-1:0] snoopAddr = '0;

  always #2.5 clk = ~clk;

  wt_snoop_cache u_wt_snoop_cache (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .busCmdValid(busCmdValid), .busCmdWrite(busCmdWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busDone(busDone),
    .snoopValid(snoopValid), .snoopSelf(snoopSelf), .snoopAddr(snoopAddr)
  );

  int checks = 0;
  int fails  = 0;
  int busReads = 0;
  int busWrites = 0;
  logic [DATA_W-1:0] mem [64];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model on the bus
  initial begin
    int waitCnt = 0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h1000_0000 + i * 3;
    forever begin
      @(negedge clk);
      if (busDone) begin
        busDone = 1'b0;
      end else if (busCmdValid) begin
        if (waitCnt == LAT - 1) begin
          waitCnt = 0;
          busDone = 1'b1;
          if (busCmdWrite) begin
            mem[busAddr[5:0]] = busWdata;
            busWrites++;
          end else begin
            busRdata = mem[busAddr[5:0]];
            busReads++;
          end
        end else begin
          waitCnt++;
        end
      end
    end
  end

  task automatic cpuAccess(input logic we, input logic [ADDR_W-1:0] addr,
                           input logic [DATA_W-1:0] wdata,
                           input bit withSnoop, input logic [ADDR_W-1:0] sAddr,
                           output logic [DATA_W-1:0] rdata, output int cycles,
                           output int nRd, output int nWr, output bit doneAtReady);
    int rd0, wr0;
    @(negedge clk);
    #0.1;
    rd0 = busReads; wr0 = busWrites;
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wdata;
    if (withSnoop) begin
      snoopValid = 1'b1; snoopSelf = 1'b0; snoopAddr = sAddr;
    end
    cycles = 0;
    forever begin
      #1;
      if (cpuReady) break;
      @(negedge clk);
      snoopValid = 1'b0;
      cycles++;
      if (cycles > 100) break;
    end
    rdata = cpuRdata;
    doneAtReady = busDone;
    @(negedge clk);
    cpuReq = 1'b0;
    snoopValid = 1'b0;
    nRd = busReads - rd0;
    nWr = busWrites - wr0;
  endtask

  task automatic snoop(input logic [ADDR_W-1:0] a, input logic self);
    @(negedge clk);
    snoopValid = 1'b1; snoopSelf = self; snoopAddr = a;
    @(negedge clk);
    snoopValid = 1'b0; snoopSelf = 1'b0;
  endtask

  localparam logic [ADDR_W-1:0] ADDR_A = 16'h0005;
  localparam logic [ADDR_W-1:0] ADDR_B = 16'h0009;
  localparam logic [ADDR_W-1:0] ADDR_C = 16'h0015;

  logic [DATA_W-1:0] rd;
  int cyc, nr, nw;
  bit dn;

  task automatic testReset();
    #1;
    check(cpuReady == 1'b0, "R11 ready low after reset", 32'(cpuReady), 0);
    check(busCmdValid == 1'b0, "R11 no bus command after reset", 32'(busCmdValid), 0);
  endtask

  task automatic testReadMiss();
    cpuAccess(0, ADDR_A, 0, 0, 0, rd, cyc, nr, nw, dn);
    check(rd == mem[5], "R1 miss data", rd, mem[5]);
    check(nr == 1 && nw == 0, "R1 one bus read", 32'(nr * 16 + nw), 32'h10);
    check(dn && cyc > 0, "R10 ready only with busDone", 32'(dn), 1);
  endtask

  task automatic testReadHit();
    cpuAccess(0, ADDR_A, 0, 0, 0, rd, cyc, nr, nw, dn);
    check(rd == mem[5], "R2 hit data", rd, mem[5]);
    check(cyc == 0, "R2 hit same cycle", 32'(cyc), 0);
    check(nr == 0 && nw == 0, "R2 no bus on hit", 32'(nr * 16 + nw), 0);
  endtask

  task automatic testWriteHit();
    cpuAccess(1, ADDR_A, 32'hCAFE_0005, 0, 0, rd, cyc, nr, nw, dn);
    check(nr == 0 && nw == 1, "R3 one bus write", 32'(nr * 16 + nw), 1);
    check(mem[5] == 32'hCAFE_0005, "R3 memory updated", mem[5], 32'hCAFE_0005);
    check(dn, "R10 write ready with busDone", 32'(dn), 1);
    cpuAccess(0, ADDR_A, 0, 0, 0, rd, cyc, nr, nw, dn);
    check(rd == 32'hCAFE_0005 && nr == 0, "R3 line holds store", rd, 32'hCAFE_0005);
  endtask

  task automatic testWriteMiss();
    cpuAccess(1, ADDR_B, 32'hBEEF_0009, 0, 0, rd, cyc, nr, nw, dn);
    check(nr == 1 && nw == 1, "R4 read then write", 32'(nr * 16 + nw), 32'h11);
    check(mem[9] == 32'hBEEF_0009, "R4 memory updated", mem[9], 32'hBEEF_0009);
    cpuAccess(0, ADDR_B, 0, 0, 0, rd, cyc, nr, nw, dn);
    check(rd == 32'hBEEF_0009 && nr == 0 && cyc == 0, "R4 line hits with store", rd, 32'hBEEF_0009);
  endtask

  task automatic testReplace();
    cpuAccess(0, ADDR_C, 0, 0, 0, rd, cyc, nr, nw, dn);
    check(nr == 1 && nw == 0, "R5 evict without write", 32'(nr * 16 + nw), 32'h10);
    check(rd == mem[21], "R5 new tag data", rd, mem[21]);
    cpuAccess(0, ADDR_A, 0, 0, 0, rd, cyc, nr, nw, dn);
    check(nr == 1 && nw == 0, "R5 evicted address misses", 32'(nr * 16 + nw), 32'h10);
    check(rd == 32'hCAFE_0005, "R5 refetched data", rd, 32'hCAFE_0005);
  endtask

  task automatic testSnoopKill();
    snoop(ADDR_A, 1'b0);
    mem[5] = 32'h5A5A_0005;
    cpuAccess(0, ADDR_A, 0, 0, 0, rd, cyc, nr, nw, dn);
    check(nr == 1, "R6 snooped line misses", 32'(nr), 1);
    check(rd == 32'h5A5A_0005, "R6 fresh data after snoop", rd, 32'h5A5A_0005);
  endtask

  task automatic testSnoopOtherTag();
    snoop(ADDR_C, 1'b0);
    cpuAccess(0, ADDR_A, 0, 0, 0, rd, cyc, nr, nw, dn);
    check(nr == 0 && cyc == 0, "R7 other tag keeps line", 32'(nr), 0);
    check(rd == 32'h5A5A_0005, "R7 data intact", rd, 32'h5A5A_0005);
  endtask

  task automatic testSelfSnoop();
    snoop(ADDR_A, 1'b1);
    cpuAccess(0, ADDR_A, 0, 0, 0, rd, cyc, nr, nw, dn);
    check(nr == 0 && cyc == 0, "R8 self snoop ignored", 32'(nr), 0);
  endtask

  task automatic testSameCycle();
    mem[5] = 32'h7777_0005;
    cpuAccess(0, ADDR_A, 0, 1, ADDR_A, rd, cyc, nr, nw, dn);
    check(cyc > 0, "R9 no hit in snoop cycle", 32'(cyc), 1);
    check(nr == 1, "R9 snoop wins, bus read", 32'(nr), 1);
    check(rd == 32'h7777_0005, "R9 fresh data", rd, 32'h7777_0005);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testReadMiss();
    testReadHit();
    testWriteHit();
    testWriteMiss();
    testReplace();
    testSnoopKill();
    testSnoopOtherTag();
    testSelfSnoop();
    testSameCycle();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule